// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the elements of a 64-bit packed register. The word is treated as two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes, chosen by a format code. A 32-bit mask gives each output lane a 4-bit selector. The low bits of the selector name the element that lane takes. The result is a plain bit move: no classification, rounding or exception flags are produced.

In single-source mode every lane reads from the first source operand. In two-source mode the top bit of each selector chooses between the first source and the previous contents of the destination register, so two vectors can be merged in one operation. Requests and results use valid/ready handshakes. By default the result leaves in the same cycle the request is accepted. A parameter can add one output register, which holds the result until it is taken.

Top module: `lane_shuffle_unit`

## Requirements
- R1: Format code 0 splits the word into 2 lanes of 32 bits, code 1 into 4 lanes of 16 bits, and code 2 into 8 lanes of 8 bits. Lane k occupies bits [k*W+W-1 : k*W] for lane width W.
- R2: Output lane i is steered by mask bits [4i+3:4i]. The low 1, 2 or 3 bits of that nibble (32-, 16- or 8-bit lanes) give the index of the source element.
- R3: In two-source mode (two_src_i = 1), nibble bit 3 set takes the element from old_dst_i, and bit 3 clear takes it from src_i.
- R4: In single-source mode nibble bit 3 has no effect and every lane reads src_i. With 32-bit lanes, masks 0x10 and 0x98 both return src_i unchanged.
- R5: Nibble bits between the index field and bit 3 are ignored, and so are nibbles for lanes above the active lane count.
- R6: With REG_OUT = 0 the result is valid in the same cycle as the request (res_valid_o follows req_valid_i), and req_ready_o follows res_ready_i.
- R7: Format code 3 is reserved. It returns an all-zero result with res_err_o high. Every other code returns res_err_o low.
- R8: With REG_OUT = 1 an accepted request appears at the outputs after one clock edge. The outputs stay stable while res_valid_o is high and res_ready_i is low. A new request is accepted only when no result is held or the held result is taken in the same cycle.
- R9: After reset the registered variant presents res_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| src_i | input | 64 | First source vector |
| old_dst_i | input | 64 | Previous destination contents (second source) |
| mask_i | input | 32 | One 4-bit selector per output lane |
| fmt_i | input | 2 | Element width code (0: 32b, 1: 16b, 2: 8b, 3: reserved) |
| two_src_i | input | 1 | 1 selects two-source mode |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumer ready |
| res_data_o | output | 64 | Shuffled vector |
| res_err_o | output | 1 | Reserved format code was used |

## Verification
The bench builds two copies at the default 64-bit width: one with REG_OUT = 0 and one with REG_OUT = 1. The unregistered copy takes a table of masks covering every format, both modes, swap, broadcast, reversal, merge and the reserved code. The table is checked in the same cycle, which brings the zero-latency path and the ignored selector bits within reach. The registered copy is driven through stalls and drains, which exposes the hold and acceptance rules that cannot arise when the stage is bypassed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    FMT_W32  = 2'd0,
    FMT_W16  = 2'd1,
    FMT_W8   = 2'd2,
    FMT_RSVD = 2'd3
  } lsu_fmt_e;

  localparam int unsigned NUM_FMT = 3;

  // Lane count for format index g (0: widest lanes).
  function automatic int unsigned lanes_of(input int unsigned g);
    return 2 << g;
  endfunction

  function automatic logic fmt_is_legal(input logic [1:0] code);
    return code != FMT_RSVD;
  endfunction

endpackage

// File: rtl/lsu_lane_pick.sv
module lsu_lane_pick #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic                   two_src_i,
  input  logic [DATA_W-1:0]      src_i,
  input  logic [DATA_W-1:0]      dst_i,
  input  logic [LANES*NIB_W-1:0] mask_i,
  output logic [DATA_W-1:0]      data_o,
  output logic [LANES-1:0]       from_dst_o
);

  logic unused_mask_bits;
  assign unused_mask_bits = ^mask_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0]  idx;
    logic              take_dst;
    logic [LANE_W-1:0] from_src;
    logic [LANE_W-1:0] from_dst;

    assign idx      = mask_i[l*NIB_W +: IDX_W];
    assign take_dst = two_src_i & mask_i[l*NIB_W + NIB_W - 1];
    assign from_src = src_i[idx*LANE_W +: LANE_W];
    assign from_dst = dst_i[idx*LANE_W +: LANE_W];

    assign data_o[l*LANE_W +: LANE_W] = take_dst ? from_dst : from_src;
    assign from_dst_o[l]              = take_dst;
  end

endmodule

// File: rtl/lsu_out_stage.sv
module lsu_out_stage #(
  parameter int unsigned DATA_W  = 64,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_err_o
);

  if (REG_OUT) begin : g_reg
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic              load;

    assign in_ready_o = !valid_q || out_ready_i;
    assign load       = in_valid_i && in_ready_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
        err_q   <= 1'b0;
      end else if (load) begin
        valid_q <= 1'b1;
        data_q  <= in_data_i;
        err_q   <= in_err_i;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end

    assign out_valid_o = valid_q;
    assign out_data_o  = data_q;
    assign out_err_o   = err_q;
  end else begin : g_pass
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;

    assign in_ready_o  = out_ready_i;
    assign out_valid_o = in_valid_i;
    assign out_data_o  = in_data_i;
    assign out_err_o   = in_err_i;
  end

endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned NIB_W   = 4,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned MAX_LANES = DATA_W / 8,
  localparam int unsigned MASK_W    = MAX_LANES * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] old_dst_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [1:0]        fmt_i,
  input  logic              two_src_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_err_o
);

  logic [DATA_W-1:0]    res_by_fmt [NUM_FMT];
  logic [MAX_LANES-1:0] dst_by_fmt [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int unsigned LANES  = lanes_of(g);
    localparam int unsigned LANE_W = DATA_W / LANES;
    logic [LANES-1:0] flags;

    lsu_lane_pick #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .NIB_W  (NIB_W)
    ) u_pick (
      .two_src_i  (two_src_i),
      .src_i      (src_i),
      .dst_i      (old_dst_i),
      .mask_i     (mask_i[LANES*NIB_W-1:0]),
      .data_o     (res_by_fmt[g]),
      .from_dst_o (flags)
    );

    assign dst_by_fmt[g] = MAX_LANES'(flags);
  end

  // Observation points for the checker.
  logic                 fmt_bad_w;
  logic [MAX_LANES-1:0] dst_pick_w;
  logic [DATA_W-1:0]    shuffled_w;

  assign fmt_bad_w  = !fmt_is_legal(fmt_i);
  assign shuffled_w = fmt_bad_w ? '0 : res_by_fmt[fmt_i];
  assign dst_pick_w = fmt_bad_w ? '0 : dst_by_fmt[fmt_i];

  lsu_out_stage #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (shuffled_w),
    .in_err_i    (fmt_bad_w),
    .out_valid_o (res_valid_o),
    .out_ready_i (res_ready_i),
    .out_data_o  (res_data_o),
    .out_err_o   (res_err_o)
  );

endmodule

// File: rtl/lsu_chk.sv
module lsu_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned MAX_LANES = 8,
  parameter bit          REG_OUT   = 1'b0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 two_src_i,
  input logic                 res_valid_o,
  input logic                 res_ready_i,
  input logic [DATA_W-1:0]    res_data_o,
  input logic                 res_err_o,
  input logic [MAX_LANES-1:0] dst_pick_w
);

  AST_SINGLE_NO_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !two_src_i |-> dst_pick_w == '0); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_err_o |-> res_data_o == '0); // R7

  if (REG_OUT) begin : g_reg_chk
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o) && $stable(res_err_o)); // R8

    AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o && !res_ready_i |-> !req_ready_o); // R8

    AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && req_ready_o |=> res_valid_o); // R8
  end else begin : g_pass_chk
    AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && req_ready_o |-> res_valid_o && res_ready_i); // R6
  end

endmodule

bind lane_shuffle_unit lsu_chk #(
  .DATA_W    (DATA_W),
  .MAX_LANES (MAX_LANES),
  .REG_OUT   (REG_OUT)
) u_lsu_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .two_src_i   (two_src_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o),
  .res_err_o   (res_err_o),
  .dst_pick_w  (dst_pick_w)
);

// File: tb/tb_lane_shuffle_unit.sv
module tb_lane_shuffle_unit;

  localparam logic [63:0] SRC = 64'h1716_1514_1312_1110;
  localparam logic [63:0] DST = 64'h2F2E_2D2C_2B2A_2928;
  localparam int NVEC = 12;

  // {fmt[1:0], two_src, mask[31:0], expected[63:0], err}
  localparam logic [99:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 32'h0000_0010, 64'h1716_1514_1312_1110, 1'b0}, // R4 identity
    {2'd0, 1'b0, 32'h0000_0098, 64'h1716_1514_1312_1110, 1'b0}, // R4 bit3 ignored
    {2'd0, 1'b0, 32'h0000_0001, 64'h1312_1110_1716_1514, 1'b0}, // R2 swap
    {2'd0, 1'b1, 32'h0000_0081, 64'h2B2A_2928_1716_1514, 1'b0}, // R3 merge
    {2'd1, 1'b0, 32'h0000_0000, 64'h1110_1110_1110_1110, 1'b0}, // R2 broadcast
    {2'd1, 1'b0, 32'h0000_0123, 64'h1110_1312_1514_1716, 1'b0}, // R2 reverse
    {2'd2, 1'b1, 32'h89AB_4567, 64'h2829_2A2B_1415_1617, 1'b0}, // R3 bytes
    {2'd2, 1'b0, 32'h0123_4567, 64'h1011_1213_1415_1617, 1'b0}, // R1 byte reverse
    {2'd0, 1'b0, 32'hABCD_EF32, 64'h1716_1514_1312_1110, 1'b0}, // R5 ignored bits
    {2'd1, 1'b1, 32'hFFFF_C6A1, 64'h2928_1514_2D2C_1312, 1'b0}, // R5 two-source
    {2'd3, 1'b1, 32'h0123_4567, 64'h0,                   1'b1}, // R7 reserved
    {2'd1, 1'b0, 32'hFFFF_C6A1, 64'h1110_1514_1514_1312, 1'b0}  // R4 16-bit
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 11: return "R4";
      2, 4, 5:  return "R2";
      3, 6:     return "R3";
      7:        return "R1";
      8, 9:     return "R5";
      default:  return "R7";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = SRC;
  logic [63:0] dst = DST;
  logic [31:0] mask = '0;
  logic [1:0]  fmt = '0;
  logic        two = 1'b0;

  logic        d_req_valid = 1'b0, d_res_ready = 1'b1;
  logic        d_req_ready, d_res_valid, d_err;
  logic [63:0] d_data;
  logic        q_req_valid = 1'b0, q_res_ready = 1'b0;
  logic        q_req_ready, q_res_valid, q_err;
  logic [63:0] q_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_shuffle_unit #(.REG_OUT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(d_req_valid), .req_ready_o(d_req_ready),
    .src_i(src), .old_dst_i(dst), .mask_i(mask), .fmt_i(fmt), .two_src_i(two),
    .res_valid_o(d_res_valid), .res_ready_i(d_res_ready), .res_data_o(d_data),
    .res_err_o(d_err));

  lane_shuffle_unit #(.REG_OUT(1'b1)) dut_q (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(q_req_valid), .req_ready_o(q_req_ready),
    .src_i(src), .old_dst_i(dst), .mask_i(mask), .fmt_i(fmt), .two_src_i(two),
    .res_valid_o(q_res_valid), .res_ready_i(q_res_ready), .res_data_o(q_data),
    .res_err_o(q_err));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input int i);
    {fmt, two, mask} = VEC[i][99:65];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {63'd0, q_res_valid}, 64'd0);
    check("R6 idle valid", {63'd0, d_res_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(i);
      d_req_valid = 1'b1;
      #1;
      check(vec_tag(i), d_data, VEC[i][64:1]);
      check({vec_tag(i), " err"}, {63'd0, d_err}, {63'd0, VEC[i][0]});
      check("R6 same-cycle valid", {63'd0, d_res_valid}, 64'd1);
    end

    @(negedge clk);
    d_res_ready = 1'b0;
    #1;
    check("R6 ready follows", {63'd0, d_req_ready}, 64'd0);
    @(negedge clk);
    d_req_valid = 1'b0;
    d_res_ready = 1'b1;

    // Registered variant: load, stall, drain.
    @(negedge clk);
    apply(2);
    q_req_valid = 1'b1;
    q_res_ready = 1'b0;
    @(posedge clk); #1;
    check("R8 loaded data", q_data, VEC[2][64:1]);
    check("R8 loaded valid", {63'd0, q_res_valid}, 64'd1);
    check("R8 full not ready", {63'd0, q_req_ready}, 64'd0);
    @(negedge clk);
    apply(4);
    @(posedge clk); #1;
    check("R8 hold data", q_data, VEC[2][64:1]);
    @(negedge clk);
    q_res_ready = 1'b1;
    #1;
    check("R8 drain ready", {63'd0, q_req_ready}, 64'd1);
    @(posedge clk); #1;
    check("R8 next data", q_data, VEC[4][64:1]);
    @(negedge clk);
    q_req_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 drained valid", {63'd0, q_res_valid}, 64'd0);
    @(negedge clk);
    apply(10);
    q_req_valid = 1'b1;
    @(posedge clk); #1;
    check("R7 registered err", {63'd0, q_err}, 64'd1);
    check("R7 registered data", q_data, 64'd0);
    @(negedge clk);
    q_req_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("TIMEOUT watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule